// File: doc/BRIEF.md
# Parallel CRC-16 / CRC-32 Signature Engine

This block is a register-mapped checksum unit. A processor or DMA engine writes data into it one byte or one 16-bit word at a time, and each accepted write folds every enabled byte into the running signature in a single clock. Two independent signatures are kept: a 16-bit one with generator 0x1021 and a 32-bit one with generator 0x04C11DB7. Both are non-reflected, and neither applies a final XOR. Each byte is absorbed most significant bit first. In a word write the low byte goes in before the high byte.

Each signature has two data entry addresses. The direct one uses the bits as written. The mirrored one reverses the bit order inside every byte before that byte is absorbed. A write to the seed/result address loads the starting value, byte-enable by byte-enable. A read of that address returns the current signature. A separate read-only address returns the signature with its whole bit order mirrored, and that value can be written straight back through the mirrored entry address to close a message with a zero residue.

Reads are registered: the data for a read issued in one cycle appears on `rdata` after the next rising edge and holds until the next read.

Top module: `pcrc_engine`

Register addresses, with a 16-bit bus: 0 = 16-bit direct entry, 1 = 16-bit mirrored entry, 2 = 16-bit seed/result, 3 = 16-bit mirrored result, 4 = 32-bit direct entry, 5 = 32-bit mirrored entry, 6/7 = 32-bit seed/result low/high half, 8/9 = 32-bit mirrored result low/high half.

## Requirements
- R1: After reset both signatures equal all ones (0xFFFF and 0xFFFFFFFF), and `rdata` reads 0 before any read is issued.
- R2: A byte write (be=01) to address 0 updates the 16-bit signature as a serial shift register with generator 0x1021 would, fed bit 7 first, with no final XOR. The ASCII string "123456789" fed from the reset seed yields 0x29B1.
- R3: In a write to an entry address, be bit 0 enables the low byte (wdata[7:0]) and be bit 1 enables the high byte (wdata[15:8]). The enabled bytes are absorbed low byte first, then high byte. With be=00 the signature is left unchanged.
- R4: A write to a mirrored entry address (1 or 5) reverses the bit order within each enabled byte before the byte is absorbed.
- R5: Addresses 4 and 5 update the 32-bit signature by the same rules, with generator 0x04C11DB7; "123456789" from the reset seed yields 0x0376E6E7. Writes to either signature's addresses leave the other signature unchanged.
- R6: A write to a seed/result address loads each byte whose be bit is set and keeps the other bytes. A read of that address returns the current signature: address 2 for the 16-bit one, addresses 6 and 7 for the low and high halves of the 32-bit one.
- R7: Address 3 returns the 16-bit signature with bit i moved to bit 15-i. Addresses 8 and 9 return the low and high halves of the 32-bit signature with bit i moved to bit 31-i.
- R8: Writing the mirrored result back through the mirrored entry address (for the 32-bit signature, the low half first and then the high half) leaves the signature at zero. Writing the 16-bit result byte-swapped to address 0 also leaves zero.
- R9: A read returns 0 for entry addresses and for addresses above 9. Writes to addresses above 9 or to mirrored result addresses change nothing. Read data appears one clock after the read strobe and holds while no read is issued.
- R10: Writes on consecutive clock cycles are each absorbed in full, with no idle cycle needed between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| be | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| rdata | output | 16 | Registered read data |

## Verification
The assertions take for granted that the direct and mirrored entry strobes of one signature never fire together, which the address decoder guarantees. They also assume that a seed load and a data absorb never land on the same signature in the same cycle, which holds because each uses its own address. The stimulus keeps to one write per cycle at a single address, always with a defined byte-enable value, including 00 and single-lane patterns. Reads run one at a time, and their result is sampled only after the registered read path has settled.

// File: rtl/pcrc_pkg.sv
package pcrc_pkg;
  localparam int ADDR_W = 4;
  localparam int BUS_W  = 16;
  localparam int NLANE  = BUS_W / 8;

  localparam logic [ADDR_W-1:0] A_D16  = 4'd0;
  localparam logic [ADDR_W-1:0] A_X16  = 4'd1;
  localparam logic [ADDR_W-1:0] A_S16  = 4'd2;
  localparam logic [ADDR_W-1:0] A_R16  = 4'd3;
  localparam logic [ADDR_W-1:0] A_D32  = 4'd4;
  localparam logic [ADDR_W-1:0] A_X32  = 4'd5;
  localparam logic [ADDR_W-1:0] A_S32L = 4'd6;
  localparam logic [ADDR_W-1:0] A_S32H = 4'd7;
  localparam logic [ADDR_W-1:0] A_R32L = 4'd8;
  localparam logic [ADDR_W-1:0] A_R32H = 4'd9;

  // one strobe per writable register
  typedef struct packed {
    logic       d16;
    logic       x16;
    logic       s16;
    logic       d32;
    logic       x32;
    logic [1:0] s32;
  } wstrb_t;

  function automatic logic [7:0] flip8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction
endpackage

// File: rtl/pcrc_regdec.sv
module pcrc_regdec
  import pcrc_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output wstrb_t            strb
);
  always_comb begin
    strb = '0;
    if (wr_en) begin
      case (addr)
        A_D16:   strb.d16    = 1'b1;
        A_X16:   strb.x16    = 1'b1;
        A_S16:   strb.s16    = 1'b1;
        A_D32:   strb.d32    = 1'b1;
        A_X32:   strb.x32    = 1'b1;
        A_S32L:  strb.s32[0] = 1'b1;
        A_S32H:  strb.s32[1] = 1'b1;
        default: strb        = '0;
      endcase
    end
  end

  // R9: at most one register is written, and never from a read-only or unmapped address
  always_comb begin
    p_single_strobe_r9: assert ($onehot0(strb));
    if (addr > A_S32H || addr == A_R16)
      p_unmapped_write_r9: assert (strb == '0);
  end
endmodule

// File: rtl/pcrc_channel.sv
module pcrc_channel
  import pcrc_pkg::*;
#(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din_we,
  input  logic             dinr_we,
  input  logic [W/BUS_W-1:0] seed_we,
  input  logic [BUS_W-1:0] wdata,
  input  logic [NLANE-1:0] be,
  output logic [W-1:0]     sig,
  output logic [W-1:0]     sig_rev
);
  localparam int NSEG = W / BUS_W;

  // one byte through a W-bit shift register, MSB first, unrolled into XOR trees
  function automatic logic [W-1:0] absorb8(input logic [W-1:0] c, input logic [7:0] d);
    logic [W-1:0] r;
    logic         fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[W-1] ^ d[i];
      r  = {r[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return r;
  endfunction

  logic         data_we;
  logic         seed_any;
  logic [7:0]   lane_b [NLANE];
  logic [W-1:0] chain  [NLANE+1];
  logic [W-1:0] seed_val;

  assign data_we  = din_we | dinr_we;
  assign seed_any = |seed_we;
  assign chain[0] = sig;

  // lane 0 first, so the low byte is absorbed before the high byte
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane_b[g]  = dinr_we ? flip8(wdata[g*8 +: 8]) : wdata[g*8 +: 8];
    assign chain[g+1] = be[g] ? absorb8(chain[g], lane_b[g]) : chain[g];
  end

  always_comb begin
    seed_val = sig;
    for (int s = 0; s < NSEG; s++)
      for (int k = 0; k < NLANE; k++)
        if (seed_we[s] && be[k])
          seed_val[s*BUS_W + k*8 +: 8] = wdata[k*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        sig <= SEED;
    else if (data_we)  sig <= chain[NLANE];
    else if (seed_any) sig <= seed_val;
  end

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign sig_rev[i] = sig[W-1-i];
  end

  // R4: the two entry ports of one signature are never strobed together
  p_port_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(din_we && dinr_we));

  // R3: no lane enabled and no seed write -> signature holds
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_any && (!data_we || be == '0)) |=> $stable(sig));

  // R6: full-width seed write lands in the low segment
  p_seed_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_we[0] && (&be) && !data_we) |=> (sig[BUS_W-1:0] == $past(wdata)));
endmodule

// File: rtl/pcrc_rdmux.sv
module pcrc_rdmux
  import pcrc_pkg::*;
#(
  parameter int NW = 16,
  parameter int WW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NW-1:0]     sig_n,
  input  logic [NW-1:0]     rev_n,
  input  logic [WW-1:0]     sig_w,
  input  logic [WW-1:0]     rev_w,
  output logic [BUS_W-1:0]  rdata
);
  logic [BUS_W-1:0] sel;

  always_comb begin
    case (addr)
      A_S16:   sel = sig_n[BUS_W-1:0];
      A_R16:   sel = rev_n[BUS_W-1:0];
      A_S32L:  sel = sig_w[BUS_W-1:0];
      A_S32H:  sel = sig_w[2*BUS_W-1:BUS_W];
      A_R32L:  sel = rev_w[BUS_W-1:0];
      A_R32H:  sel = rev_w[2*BUS_W-1:BUS_W];
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= sel;
  end

  // R9: read data changes only in answer to a read strobe
  p_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr > A_R32H) |=> (rdata == '0));
endmodule

// File: rtl/pcrc_engine.sv
module pcrc_engine
  import pcrc_pkg::*;
#(
  parameter int            NARROW_W = 16,
  parameter int            WIDE_W   = 32,
  parameter logic [15:0]   POLY_N   = 16'h1021,
  parameter logic [31:0]   POLY_W   = 32'h04C11DB7,
  parameter logic [15:0]   SEED_N   = 16'hFFFF,
  parameter logic [31:0]   SEED_W   = 32'hFFFFFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [NLANE-1:0]  be,
  output logic [BUS_W-1:0]  rdata
);
  wstrb_t              strb;
  logic [NARROW_W-1:0] sig_n, rev_n;
  logic [WIDE_W-1:0]   sig_w, rev_w;

  pcrc_regdec u_dec (.wr_en(wr_en), .addr(addr), .strb(strb));

  pcrc_channel #(.W(NARROW_W), .POLY(POLY_N), .SEED(SEED_N)) u_narrow (
    .clk(clk), .rst_n(rst_n), .din_we(strb.d16), .dinr_we(strb.x16),
    .seed_we(strb.s16), .wdata(wdata), .be(be), .sig(sig_n), .sig_rev(rev_n));

  pcrc_channel #(.W(WIDE_W), .POLY(POLY_W), .SEED(SEED_W)) u_wide (
    .clk(clk), .rst_n(rst_n), .din_we(strb.d32), .dinr_we(strb.x32),
    .seed_we(strb.s32), .wdata(wdata), .be(be), .sig(sig_w), .sig_rev(rev_w));

  pcrc_rdmux #(.NW(NARROW_W), .WW(WIDE_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
    .sig_n(sig_n), .rev_n(rev_n), .sig_w(sig_w), .rev_w(rev_w), .rdata(rdata));

  function automatic logic [NARROW_W-1:0] mirror_n(input logic [NARROW_W-1:0] v);
    logic [NARROW_W-1:0] r;
    r = '0;
    for (int i = 0; i < NARROW_W; i++) r = (r << 1) | NARROW_W'(v[i]);
    return r;
  endfunction

  // R6: result read returns the signature of the read cycle
  p_result_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_S16) |=> (rdata == $past(sig_n)));
  // R7: mirrored read returns the signature with its bit order reversed
  p_rev_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_R16) |=> (rdata == mirror_n($past(sig_n))));
  // R5: 16-bit traffic never disturbs the 32-bit signature
  p_isolated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr <= A_R16) |=> $stable(sig_w));
endmodule

// File: tb/pcrc_engine_bench.sv
`timescale 1ns/1ps
module pcrc_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic [15:0] rdata;

  int checks = 0, errors = 0;
  bit done = 0;
  longint m16, m32;
  logic [31:0] lcg = 32'h1234_5678;

  always #2.5 clk = ~clk;

  pcrc_engine u_pcrc_engine (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .be(be), .rdata(rdata));

  function automatic logic [31:0] rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  // serial reference: one bit at a time, order chosen per port
  function automatic longint feed(longint c, int w, longint poly, logic [7:0] b, bit mirrored);
    longint mask = (64'sd1 <<< w) - 1;
    for (int k = 0; k < 8; k++) begin
      longint top = (c >>> (w - 1)) & 1;
      int bitv = mirrored ? int'(b[k]) : int'(b[7-k]);
      c = (c <<< 1) & mask;
      if ((top ^ longint'(bitv)) != 0) c = c ^ poly;
    end
    return c;
  endfunction

  task automatic model(input logic [3:0] a, input logic [15:0] d, input logic [1:0] b);
    for (int l = 0; l < 2; l++) begin
      if (b[l]) begin
        case (a)
          4'd0: m16 = feed(m16, 16, 64'h1021, d[l*8 +: 8], 0);
          4'd1: m16 = feed(m16, 16, 64'h1021, d[l*8 +: 8], 1);
          4'd2: m16 = (m16 & ~(64'hFF << (8*l))) | (longint'(d[l*8 +: 8]) << (8*l));
          4'd4: m32 = feed(m32, 32, 64'h04C11DB7, d[l*8 +: 8], 0);
          4'd5: m32 = feed(m32, 32, 64'h04C11DB7, d[l*8 +: 8], 1);
          4'd6: m32 = (m32 & ~(64'hFF << (8*l))) | (longint'(d[l*8 +: 8]) << (8*l));
          4'd7: m32 = (m32 & ~(64'hFF << (8*l+16))) | (longint'(d[l*8 +: 8]) << (8*l+16));
          default: ;
        endcase
      end
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_nb(input logic [3:0] a, input logic [15:0] d, input logic [1:0] b);
    @(negedge clk);
    wr_en = 1; rd_en = 0; addr = a; wdata = d; be = b;
    model(a, d, b);
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] b);
    wr_nb(a, d, b);
    idle();
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    wr_en = 0; rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  task automatic cmp16(input string req);
    logic [15:0] v;
    rd(4'd2, v);
    chk(req, {16'h0, v}, 32'(m16));
  endtask

  task automatic cmp32(input string req);
    logic [15:0] lo, hi;
    rd(4'd6, lo);
    rd(4'd7, hi);
    chk(req, {hi, lo}, 32'(m32));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] v, lo, hi;
    string msg;
    m16 = 64'hFFFF; m32 = 64'hFFFFFFFF;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rdata after reset", {16'h0, rdata}, 32'h0);
    cmp16("R1 reset seed 16");
    cmp32("R1 reset seed 32");

    // R2 / R5 check strings
    for (int i = 0; i < 9; i++) wr(4'd0, 16'(8'h31 + i), 2'b01);
    rd(4'd2, v); chk("R2 check string 16", {16'h0, v}, 32'h29B1);
    for (int i = 0; i < 9; i++) wr(4'd4, 16'(8'h31 + i), 2'b01);
    rd(4'd6, lo); rd(4'd7, hi); chk("R5 check string 32", {hi, lo}, 32'h0376E6E7);

    // R3 lane patterns including be=00 and high-lane only
    wr(4'd0, 16'hA55A, 2'b11); cmp16("R3 word low-then-high");
    wr(4'd0, 16'h3C00, 2'b10); cmp16("R3 high lane only");
    wr(4'd0, 16'hFFFF, 2'b00); cmp16("R3 no lane enabled");
    // R4 mirrored entry
    wr(4'd1, 16'h0180, 2'b11); cmp16("R4 mirrored word 16");
    wr(4'd5, 16'h00E1, 2'b01); cmp32("R4 mirrored byte 32");
    // R6 partial seeds
    wr(4'd2, 16'hAB00, 2'b10); cmp16("R6 seed high byte 16");
    wr(4'd7, 16'h1234, 2'b11); wr(4'd6, 16'h0056, 2'b01); cmp32("R6 seed 32 halves");
    // R7 mirrored readback
    rd(4'd3, v);
    for (int i = 0; i < 16; i++) lo[i] = m16[15-i];
    chk("R7 mirrored result 16", {16'h0, v}, {16'h0, lo});
    rd(4'd8, lo); rd(4'd9, hi);
    begin
      logic [31:0] e;
      for (int i = 0; i < 32; i++) e[i] = m32[31-i];
      chk("R7 mirrored result 32", {hi, lo}, e);
    end

    // R5 isolation plus random traffic against the model
    for (int n = 0; n < 60; n++) begin
      logic [31:0] r = rnd();
      logic [3:0] a;
      case (r[2:0])
        3'd0, 3'd1: a = 4'd0;
        3'd2: a = 4'd1;
        3'd3: a = 4'd4;
        3'd4: a = 4'd5;
        3'd5: a = 4'd2;
        3'd6: a = 4'd6;
        default: a = 4'd3;
      endcase
      wr(a, r[31:16], r[4:3]);
      $sformat(msg, "R5 random op %0d addr %0d 16", n, a);
      cmp16(msg);
      $sformat(msg, "R5 random op %0d addr %0d 32", n, a);
      cmp32(msg);
    end

    // R10 back-to-back
    wr_nb(4'd0, 16'h1357, 2'b11); wr_nb(4'd1, 16'h2468, 2'b11);
    wr_nb(4'd4, 16'h9ABC, 2'b11); wr_nb(4'd5, 16'hDEF0, 2'b10);
    idle();
    cmp16("R10 back-to-back 16"); cmp32("R10 back-to-back 32");

    // R8 zero residue
    rd(4'd3, v); wr(4'd1, v, 2'b11);
    rd(4'd2, v); chk("R8 residue mirrored 16", {16'h0, v}, 32'h0);
    wr(4'd0, 16'hBEEF, 2'b11); wr(4'd0, 16'h0042, 2'b01);
    rd(4'd2, v); wr(4'd0, {v[7:0], v[15:8]}, 2'b11);
    rd(4'd2, v); chk("R8 residue direct 16", {16'h0, v}, 32'h0);
    rd(4'd8, lo); rd(4'd9, hi);
    wr(4'd5, lo, 2'b11); wr(4'd5, hi, 2'b11);
    rd(4'd6, lo); rd(4'd7, hi); chk("R8 residue mirrored 32", {hi, lo}, 32'h0);

    // R9 reads of entry/unmapped addresses, writes to read-only/unmapped
    wr(4'd2, 16'h5A5A, 2'b11);
    rd(4'd0, v); chk("R9 read entry 16", {16'h0, v}, 32'h0);
    rd(4'd5, v); chk("R9 read entry 32", {16'h0, v}, 32'h0);
    rd(4'd12, v); chk("R9 read unmapped", {16'h0, v}, 32'h0);
    wr(4'd15, 16'h1111, 2'b11); wr(4'd3, 16'h2222, 2'b11); wr(4'd9, 16'h3333, 2'b11);
    cmp16("R9 ignored writes 16"); cmp32("R9 ignored writes 32");
    rd(4'd2, v);
    repeat (3) idle();
    chk("R9 read data holds", {16'h0, rdata}, {16'h0, v});

    finish_run();
  end
endmodule